// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This engine paints or moves rectangular regions of a 16-bit-per-pixel frame buffer held in a simple synchronous memory. Software or a command sequencer places the rectangle geometry on the inputs and pulses one of two start strobes. The engine then walks the rectangle row by row. A fill writes one pixel per cycle with a fixed colour. A copy reads a source pixel and writes it to the destination, and still keeps one pixel per cycle by overlapping the read of the next pixel with the write of the current one.

Positions are linear byte addresses: a pixel at column x and row y sits at `(y * screen_width + x) * 2`. The row stride in bytes is a configuration input, and extents are given as width minus one and height minus one. When a copy's source lies at a lower address than its destination, the walk runs from the bottom-right pixel backwards, so overlapping regions are moved without corruption.

Top module: `blit_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_wr_en` and `mem_rd_en` are all 0.
- R2: A fill writes `fill_color` to every pixel at byte address `dst_addr + r*stride + 2*c`, for r in 0..height_m1 and c in 0..width_m1, and writes no other address.
- R3: Extents are minus-one counts. Both fields at 0 give a single pixel, and that operation keeps `busy` high for exactly 2 cycles.
- R4: One pixel is issued per cycle. `busy` rises in the cycle after an accepted start and stays high for (width*height)+1 cycles.
- R5: A copy reads each source pixel at `src_addr + r*stride + 2*c` and writes the value, bit for bit, to the matching destination pixel. Memory read data is taken one cycle after `mem_rd_en`.
- R6: If `src_addr < dst_addr`, the copy runs from the bottom-right pixel backwards. An overlapping copy then leaves the destination equal to the original source contents. This relies on the memory returning the old data when a read and a write hit the same address in the same cycle.
- R7: If `src_addr >= dst_addr`, the copy runs forward, and an overlapping copy again reproduces the original source contents.
- R8: `done` is a one-cycle pulse in the cycle after the last write, which is also the first cycle with `busy` low.
- R9: A start strobe seen while `busy` is high is ignored. The running operation keeps its parameters and length, and the ignored request writes nothing.
- R10: Pixels are RGB565 (red 15:11, green 10:5, blue 4:0). The colour is written unchanged, with every field intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_fill | input | 1 | Start a fill (accepted only when idle) |
| start_copy | input | 1 | Start a copy (accepted only when idle; wins over start_fill) |
| dst_addr | input | AW | Destination top-left byte address |
| src_addr | input | AW | Source top-left byte address |
| width_m1 | input | CW | Width minus one |
| height_m1 | input | CW | Height minus one |
| fill_color | input | PW | RGB565 fill colour |
| stride | input | SW | Row stride in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | AW | Memory read byte address |
| mem_rd_data | input | PW | Memory read data, one cycle after the read |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | AW | Memory write byte address |
| mem_wr_data | output | PW | Memory write data |

## Verification
The completion pulse of one operation and the acceptance of the next start can happen in the same cycle, because `busy` is already low while `done` is high. The bench waits for the cycle in which `done` appears and drives the next start in that same cycle. It then checks that the first operation finished normally, that the second was accepted and ran for its full length, and that the memory holds both results in order. A separate case raises a start strobe in the middle of a run and checks that the run's length and the memory contents are unchanged.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic {
    OP_FILL = 1'b0,
    OP_COPY = 1'b1
  } blit_op_e;
endpackage

// File: rtl/blit_addr_walk.sv
// Walks one byte address through a rectangle, forward or backward.
module blit_addr_walk #(
  parameter int AW = 20,
  parameter int CW = 10,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          back,
  input  logic [CW-1:0] wm1,
  input  logic [CW-1:0] hm1,
  input  logic [SW-1:0] stride,
  input  logic          step,
  input  logic          row_end,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] PIX_BYTES = AW'(2);

  logic [AW-1:0] gap_q;
  logic          back_q;
  logic [AW-1:0] row_len;

  assign row_len = AW'(wm1) << 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      gap_q  <= '0;
      back_q <= 1'b0;
    end else if (load) begin
      gap_q  <= AW'(stride) - row_len;
      back_q <= back;
      cur    <= back ? base + AW'(hm1) * AW'(stride) + row_len : base;
    end else if (step) begin
      if (row_end) cur <= back_q ? cur - gap_q : cur + gap_q;
      else         cur <= back_q ? cur - PIX_BYTES : cur + PIX_BYTES;
    end
  end
endmodule

// File: rtl/blit_seq.sv
// Column/row counters that pace one pixel per cycle.
module blit_seq #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [CW-1:0] wm1,
  input  logic [CW-1:0] hm1,
  output logic          run,
  output logic          row_end,
  output logic          last
);
  logic [CW-1:0] x_q, y_q;

  assign row_end = (x_q == wm1);
  assign last    = row_end && (y_q == hm1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      x_q <= '0;
      y_q <= '0;
    end else if (go) begin
      run <= 1'b1;
      x_q <= '0;
      y_q <= '0;
    end else if (run) begin
      if (last) begin
        run <= 1'b0;
      end else if (row_end) begin
        x_q <= '0;
        y_q <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  // R3: column counter never passes the programmed extent
  a_r3_x_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (x_q <= wm1 && y_q <= hm1));
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 10,
  parameter int SW = 12,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_fill,
  input  logic          start_copy,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] src_addr,
  input  logic [CW-1:0] width_m1,
  input  logic [CW-1:0] height_m1,
  input  logic [PW-1:0] fill_color,
  input  logic [SW-1:0] stride,
  output logic          busy,
  output logic          done,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [PW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [PW-1:0] mem_wr_data
);
  localparam int NWALK = 2;  // 0: destination, 1: source
  localparam int W_DST = 0;
  localparam int W_SRC = 1;

  blit_op_e      op_q;
  logic [PW-1:0] color_q;
  logic [CW-1:0] wm1_q, hm1_q;
  logic          go, back_go;
  logic          run, row_end, last;
  logic          wr_last_q;
  logic [AW-1:0] walk_base [NWALK];
  logic [AW-1:0] walk_cur  [NWALK];

  assign go      = !busy && (start_fill || start_copy);
  assign back_go = start_copy && (src_addr < dst_addr);

  assign walk_base[W_DST] = dst_addr;
  assign walk_base[W_SRC] = src_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_FILL;
      color_q <= '0;
      wm1_q   <= '0;
      hm1_q   <= '0;
    end else if (go) begin
      op_q    <= start_copy ? OP_COPY : OP_FILL;
      color_q <= fill_color;
      wm1_q   <= width_m1;
      hm1_q   <= height_m1;
    end
  end

  blit_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .go(go), .wm1(wm1_q), .hm1(hm1_q),
    .run(run), .row_end(row_end), .last(last)
  );

  for (genvar i = 0; i < NWALK; i++) begin : g_walk
    blit_addr_walk #(.AW(AW), .CW(CW), .SW(SW)) u_walk (
      .clk(clk), .rst(rst), .load(go), .base(walk_base[i]), .back(back_go),
      .wm1(width_m1), .hm1(height_m1), .stride(stride),
      .step(run), .row_end(row_end), .cur(walk_cur[i])
    );
  end

  // Issue stage: the read goes out together with the pixel it belongs to.
  assign mem_rd_en   = run && (op_q == OP_COPY);
  assign mem_rd_addr = walk_cur[W_SRC];

  // Write stage: one cycle behind the issue stage, aligned with read data.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      wr_last_q   <= 1'b0;
      done        <= 1'b0;
    end else begin
      mem_wr_en   <= run;
      mem_wr_addr <= walk_cur[W_DST];
      wr_last_q   <= run && last;
      done        <= mem_wr_en && wr_last_q;
    end
  end

  assign mem_wr_data = (op_q == OP_COPY) ? mem_rd_data : color_q;
  assign busy        = run || mem_wr_en;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: the engine goes idle exactly when completion is flagged
  a_r8_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R9: a start while busy leaves the captured operation untouched
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy && (start_fill || start_copy)) |=>
      ($stable(op_q) && $stable(color_q) && $stable(wm1_q) && $stable(hm1_q)));
  // R5: every copy write follows a read one cycle earlier
  a_r5_read_first: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && op_q == OP_COPY) |-> $past(mem_rd_en));
  // R4: each issued pixel becomes a write in the next cycle
  a_r4_issue_write: assert property (@(posedge clk) disable iff (rst)
    run |=> mem_wr_en);
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb;
  localparam int AW = 20, CW = 10, SW = 12, PW = 16;
  localparam int ROWPIX = 32;
  localparam int MWORDS = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_fill = 1'b0, start_copy = 1'b0;
  logic [AW-1:0] dst_addr = '0, src_addr = '0;
  logic [CW-1:0] width_m1 = '0, height_m1 = '0;
  logic [PW-1:0] fill_color = '0;
  logic [SW-1:0] stride = SW'(ROWPIX * 2);
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [PW-1:0] mem_rd_data, mem_wr_data;

  logic [PW-1:0] mem  [MWORDS];
  logic [PW-1:0] expm [MWORDS];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  blit_engine #(.AW(AW), .CW(CW), .SW(SW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .start_fill(start_fill), .start_copy(start_copy),
    .dst_addr(dst_addr), .src_addr(src_addr), .width_m1(width_m1),
    .height_m1(height_m1), .fill_color(fill_color), .stride(stride),
    .busy(busy), .done(done), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  // Synchronous memory, old data on same-cycle read/write.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[12:1]];
    if (mem_wr_en) mem[mem_wr_addr[12:1]] <= mem_wr_data;
  end

  initial begin
    for (int i = 0; i < MWORDS; i++) begin
      mem[i]  = 16'(i) ^ 16'hA5A5;
      expm[i] = 16'(i) ^ 16'hA5A5;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pix(input int x, input int y);
    return y * ROWPIX + x;
  endfunction

  task automatic apply_exp(input bit cp, input int sx, input int sy, input int dx,
                           input int dy, input int w, input int h, input logic [15:0] col);
    logic [PW-1:0] tmp [MWORDS];
    for (int i = 0; i < MWORDS; i++) tmp[i] = expm[i];
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        expm[pix(dx + c, dy + r)] = cp ? tmp[pix(sx + c, sy + r)] : col;
  endtask

  task automatic start_op(input bit cp, input int sx, input int sy, input int dx,
                          input int dy, input int w, input int h, input logic [15:0] col);
    src_addr   = AW'(pix(sx, sy) * 2);
    dst_addr   = AW'(pix(dx, dy) * 2);
    width_m1   = CW'(w - 1);
    height_m1  = CW'(h - 1);
    fill_color = col;
    start_copy = cp;
    start_fill = !cp;
    apply_exp(cp, sx, sy, dx, dy, w, h, col);
  endtask

  // Returns in the cycle where done should be high.
  task automatic wait_finish(input int exp_busy, input string req, input int inject_at);
    int bc = 0;
    @(negedge clk);
    start_fill = 1'b0;
    start_copy = 1'b0;
    while (busy) begin
      bc++;
      if (bc == inject_at) begin
        start_copy = 1'b1;
        dst_addr   = AW'(pix(20, 20) * 2);
        src_addr   = AW'(pix(0, 0) * 2);
        width_m1   = CW'(7);
        height_m1  = CW'(7);
        fill_color = 16'h1234;
      end else begin
        start_copy = 1'b0;
      end
      @(negedge clk);
    end
    start_copy = 1'b0;
    check(bc == exp_busy, {req, " busy length"}, bc, exp_busy);
    check(done == 1'b1, "R8 done after last write", int'(done), 1);
  endtask

  task automatic compare_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < MWORDS; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first >= 0)
      check(1'b0, req, int'(mem[first]), int'(expm[first]));
    else
      check(1'b1, req, 0, 0);
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(mem_wr_en == 1'b0, "R1 wr_en", int'(mem_wr_en), 0);
    check(mem_rd_en == 1'b0, "R1 rd_en", int'(mem_rd_en), 0);
  endtask

  task automatic t_fill;  // R2 R4 R10
    @(negedge clk);
    start_op(1'b0, 0, 0, 3, 2, 5, 4, 16'hF81F);
    wait_finish(21, "R4", 0);
    @(negedge clk);
    check(done == 1'b0, "R8 single-cycle done", int'(done), 0);
    compare_mem("R2 R10 fill contents");
  endtask

  task automatic t_single;  // R3
    @(negedge clk);
    start_op(1'b0, 0, 0, 10, 1, 1, 1, 16'h07E0);
    wait_finish(2, "R3", 0);
    compare_mem("R3 single pixel");
  endtask

  task automatic t_copy_fwd;  // R5
    @(negedge clk);
    start_op(1'b1, 0, 10, 16, 12, 7, 3, 16'h0);
    wait_finish(22, "R5", 0);
    compare_mem("R5 disjoint copy");
  endtask

  task automatic t_copy_back;  // R6
    @(negedge clk);
    start_op(1'b1, 2, 20, 4, 21, 6, 4, 16'h0);
    wait_finish(25, "R6", 0);
    compare_mem("R6 overlap copy backward");
  endtask

  task automatic t_copy_overlap_fwd;  // R7
    @(negedge clk);
    start_op(1'b1, 5, 26, 3, 25, 6, 3, 16'h0);
    wait_finish(19, "R7", 0);
    compare_mem("R7 overlap copy forward");
  endtask

  task automatic t_ignore;  // R9
    @(negedge clk);
    start_op(1'b0, 0, 0, 12, 6, 4, 3, 16'h001F);
    wait_finish(13, "R9", 4);
    compare_mem("R9 ignored start writes nothing");
  endtask

  task automatic t_back_to_back;  // R8 R4
    @(negedge clk);
    start_op(1'b0, 0, 0, 24, 14, 3, 2, 16'hFFE0);
    wait_finish(7, "R4 first", 0);
    start_op(1'b1, 24, 14, 24, 17, 3, 2, 16'h0);
    wait_finish(7, "R8 start in done cycle", 0);
    compare_mem("R8 back-to-back contents");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_fill();
    t_single();
    t_copy_fwd();
    t_copy_back();
    t_copy_overlap_fwd();
    t_ignore();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule